// File: doc/BRIEF.md
# UART Interrupt Identification Arbiter

This block chooses which one of a 16550-style serial port's interrupt causes is reported to the host at any moment. Five sources compete in a fixed order. Each is qualified by its bit in a 4-bit enable register, and the winner is encoded into the identification byte the host reads. A single interrupt line is raised whenever some cause is reported.

The block owns a small amount of state: the enable register, the sticky break and overrun flags of the line status, and the "transmit holding empty" pending flag. It also applies the side effects of host reads. Reading the identification byte while it shows the transmit-empty cause drops that cause. Reading the line status drops the break and overrun flags. Every other condition arrives as a level from the receive path, the FIFO counters, the timeout timer and the modem-line logic. The identification byte and the interrupt line are registered and recomputed on every clock.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset the enable register reads 0, `iir_o` reads 0x01, `irq_o` is low and `err_o` is 0.
- R2: An enable write stores only `ier_wdata_i[3:0]`, and `ier_o` shows that value from the next cycle on. The bits are: bit0 received data and timeout, bit1 transmit empty, bit2 line status, bit3 modem status.
- R3: When several causes are enabled and active, the reported one is chosen in this order, highest first: line status, character timeout, data available, transmit empty, modem status.
- R4: The low nibble of `iir_o` is 0x6 for line status, 0xC for timeout, 0x4 for data available, 0x2 for transmit empty, 0x0 for modem status and 0x1 for none. `irq_o` is high exactly when that nibble differs from 0x1.
- R5: Line status needs enable bit2 and at least one error flag. The flags appear in `err_o` as bit0 overrun, bit1 parity, bit2 framing, bit3 break.
- R6: The character timeout cause is gated by enable bit0, the same bit that gates data available.
- R7: Data available needs `data_ready_i`. With `fifo_en_i` high it also needs `rx_count_i >= trig_level_i`. With `fifo_en_i` low, `data_ready_i` alone is enough.
- R8: A host read of the identification byte while its nibble is 0x2 clears the transmit-empty pending flag. A read that shows any other code leaves that flag alone.
- R9: An enable write while `thr_empty_i` is high sets the transmit-empty pending flag.
- R10: A line status read clears the overrun and break flags but not parity or framing. An overrun or break event in the same cycle as the read wins, and its flag stays set.
- R11: `iir_o[7:6]` read 2'b11 while FIFOs are enabled and 2'b00 otherwise. `iir_o[5:4]` are always 0.
- R12: `thre_set_i` sets the transmit-empty pending flag and `thr_write_i` clears it. A set in the same cycle as any clear wins.
- R13: `iir_o` and `irq_o` reflect the inputs and events sampled at the preceding rising edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| ier_o | output | 4 | Enable register contents |
| oe_set_i | input | 1 | Overrun event pulse |
| bi_set_i | input | 1 | Break event pulse |
| pe_i | input | 1 | Parity error level from the receive path |
| fe_i | input | 1 | Framing error level from the receive path |
| lsr_rd_i | input | 1 | Host read of line status |
| err_o | output | 4 | Error flags {break, framing, parity, overrun} |
| data_ready_i | input | 1 | Receive data ready |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| trig_level_i | input | CNT_W | Receive trigger level |
| timeout_i | input | 1 | Character timeout pending |
| thr_empty_i | input | 1 | Holding register empty level |
| thre_set_i | input | 1 | Holding register became empty pulse |
| thr_write_i | input | 1 | Host wrote holding register pulse |
| msr_delta_i | input | 4 | Modem status delta bits |
| iir_rd_i | input | 1 | Host read of identification byte |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first is a line status read that clears the overrun flag while a new overrun arrives. The second is an identification read that consumes the transmit-empty cause while the transmitter signals empty again. Each pair is provoked by pulsing both inputs on the same negative edge. The outcome is judged one edge later at the ports: the overrun flag in `err_o` must stay set, and the identification nibble must still read 0x2. Around these cases a full sweep of all 16 enable patterns against all 32 on/off patterns of the five sources checks the ordering and the codes against values computed in the bench.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned IER_W = 4;
  localparam int unsigned N_SRC = 5;
  localparam logic [3:0] ID_NONE = 4'h1;

  // source index 0 is highest priority
  typedef enum logic [2:0] {
    SRC_LINE = 3'd0,
    SRC_TOUT = 3'd1,
    SRC_DATA = 3'd2,
    SRC_THRE = 3'd3,
    SRC_MODEM = 3'd4
  } src_e;

  function automatic logic [3:0] src_id(input int unsigned idx);
    case (idx)
      0: src_id = 4'h6;
      1: src_id = 4'hC;
      2: src_id = 4'h4;
      3: src_id = 4'h2;
      default: src_id = 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_err.sv
module uart_irq_err (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       oe_set_i,
  input  logic       bi_set_i,
  input  logic       lsr_rd_i,
  input  logic       pe_i,
  input  logic       fe_i,
  output logic [3:0] err_d_o,
  output logic [3:0] err_o
);
  logic oe_q, bi_q, oe_d, bi_d;

  // new event beats the read-clear
  assign oe_d = oe_set_i | (oe_q & ~lsr_rd_i);
  assign bi_d = bi_set_i | (bi_q & ~lsr_rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q <= 1'b0;
      bi_q <= 1'b0;
    end else begin
      oe_q <= oe_d;
      bi_q <= bi_d;
    end
  end

  assign err_d_o = {bi_d, fe_i, pe_i, oe_d};
  assign err_o   = {bi_q, fe_i, pe_i, oe_q};
endmodule

// File: rtl/uart_irq_thr.sv
module uart_irq_thr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_d_o
);
  logic pend_q;

  assign pend_d_o = set_i | (pend_q & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d_o;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [N_SRC-1:0] req_i,
  output logic [3:0]       id_o
);
  always_comb begin
    id_o = ID_NONE;
    // walk from lowest to highest so the highest active wins
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = src_id(i);
    end
  end
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_we_i,
  input  logic [7:0]       ier_wdata_i,
  output logic [IER_W-1:0] ier_o,
  input  logic             oe_set_i,
  input  logic             bi_set_i,
  input  logic             pe_i,
  input  logic             fe_i,
  input  logic             lsr_rd_i,
  output logic [3:0]       err_o,
  input  logic             data_ready_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] trig_level_i,
  input  logic             timeout_i,
  input  logic             thr_empty_i,
  input  logic             thre_set_i,
  input  logic             thr_write_i,
  input  logic [3:0]       msr_delta_i,
  input  logic             iir_rd_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic [IER_W-1:0] ier_q, ier_d;
  logic [3:0]       err_d;
  logic             thr_pend_d, thr_set, thr_clr;
  logic             data_avail;
  logic [N_SRC-1:0] req;
  logic [3:0]       id_d, id_q;
  logic             fifo_q, irq_q;

  assign ier_d = ier_we_i ? ier_wdata_i[IER_W-1:0] : ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ier_q <= '0;
    else         ier_q <= ier_d;
  end

  uart_irq_err u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .oe_set_i (oe_set_i),
    .bi_set_i (bi_set_i),
    .lsr_rd_i (lsr_rd_i),
    .pe_i     (pe_i),
    .fe_i     (fe_i),
    .err_d_o  (err_d),
    .err_o    (err_o)
  );

  assign thr_set = thre_set_i | (ier_we_i & thr_empty_i);
  assign thr_clr = thr_write_i | (iir_rd_i && id_q == src_id(SRC_THRE));

  uart_irq_thr u_thr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (thr_set),
    .clr_i    (thr_clr),
    .pend_d_o (thr_pend_d)
  );

  assign data_avail = data_ready_i & (~fifo_en_i | (rx_count_i >= trig_level_i));

  assign req[SRC_LINE]  = ier_d[2] & (|err_d);
  assign req[SRC_TOUT]  = ier_d[0] & timeout_i;
  assign req[SRC_DATA]  = ier_d[0] & data_avail;
  assign req[SRC_THRE]  = ier_d[1] & thr_pend_d;
  assign req[SRC_MODEM] = ier_d[3] & (|msr_delta_i);

  uart_irq_prio u_prio (
    .req_i (req),
    .id_o  (id_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= ID_NONE;
      fifo_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      id_q   <= id_d;
      fifo_q <= fifo_en_i;
      irq_q  <= (id_d != ID_NONE);
    end
  end

  assign ier_o = ier_q;
  assign iir_o = {fifo_q, fifo_q, 2'b00, id_q};
  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ier_we_i,
  input logic [7:0] ier_wdata_i,
  input logic [3:0] ier_o,
  input logic       oe_set_i,
  input logic       bi_set_i,
  input logic       lsr_rd_i,
  input logic [3:0] err_o,
  input logic       thr_empty_i,
  input logic       thre_set_i,
  input logic       iir_rd_i,
  input logic [7:0] iir_o,
  input logic       irq_o
);
  p_irq_follows_id_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iir_o[3:0] != 4'h1));

  p_ier_low_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_we_i |=> ier_o == $past(ier_wdata_i[3:0]));

  p_timeout_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_o[0] |-> (iir_o[3:0] != 4'hC && iir_o[3:0] != 4'h4));

  p_lsr_read_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !oe_set_i && !bi_set_i) |=> (!err_o[0] && !err_o[3]));

  p_overrun_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_set_i |=> err_o[0]);

  p_thr_read_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && iir_o[3:0] == 4'h2 && !thre_set_i && !(ier_we_i && thr_empty_i))
    |=> iir_o[3:0] != 4'h2);

  p_upper_bits_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[5:4] == 2'b00 && iir_o[7] == iir_o[6]);
endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ier_we_i    (ier_we_i),
  .ier_wdata_i (ier_wdata_i),
  .ier_o       (ier_o),
  .oe_set_i    (oe_set_i),
  .bi_set_i    (bi_set_i),
  .lsr_rd_i    (lsr_rd_i),
  .err_o       (err_o),
  .thr_empty_i (thr_empty_i),
  .thre_set_i  (thre_set_i),
  .iir_rd_i    (iir_rd_i),
  .iir_o       (iir_o),
  .irq_o       (irq_o)
);

// File: tb/uart_irq_arbiter_bench.sv
module uart_irq_arbiter_bench;
  localparam int CNT_W = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ier_we = 0; logic [7:0] ier_wdata = 0; logic [3:0] ier_o;
  logic oe_set = 0, bi_set = 0, pe = 0, fe = 0, lsr_rd = 0;
  logic [3:0] err_o;
  logic dr = 0, fifo_en = 0, tout = 0, thr_empty = 0, thre_set = 0, thr_write = 0, iir_rd = 0;
  logic [CNT_W-1:0] cnt = 0, trig = 0;
  logic [3:0] msd = 0;
  logic [7:0] iir_o;
  logic irq_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_arbiter #(.CNT_W(CNT_W)) u_uart_irq_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .ier_we_i(ier_we), .ier_wdata_i(ier_wdata), .ier_o(ier_o),
    .oe_set_i(oe_set), .bi_set_i(bi_set), .pe_i(pe), .fe_i(fe), .lsr_rd_i(lsr_rd), .err_o(err_o),
    .data_ready_i(dr), .fifo_en_i(fifo_en), .rx_count_i(cnt), .trig_level_i(trig),
    .timeout_i(tout), .thr_empty_i(thr_empty), .thre_set_i(thre_set), .thr_write_i(thr_write),
    .msr_delta_i(msd), .iir_rd_i(iir_rd), .iir_o(iir_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clear_pulses();
    ier_we = 0; oe_set = 0; bi_set = 0; lsr_rd = 0; thre_set = 0; thr_write = 0; iir_rd = 0;
  endtask

  // expected id from requirement order R3 and codes R4
  function automatic logic [3:0] exp_id(input logic [3:0] en, input logic [4:0] s);
    if (en[2] && s[0]) return 4'h6;
    if (en[0] && s[1]) return 4'hC;
    if (en[0] && s[2]) return 4'h4;
    if (en[1] && s[3]) return 4'h2;
    if (en[3] && s[4]) return 4'h0;
    return 4'h1;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ier", {4'h0, ier_o}, 8'h00);
    chk("R1 iir", iir_o, 8'h01);
    chk("R1 irq", {7'h0, irq_o}, 8'h00);
    chk("R1 err", {4'h0, err_o}, 8'h00);
    rst_ni = 1;
    step();

    // R2 upper write bits dropped
    ier_we = 1; ier_wdata = 8'hF5; step(); clear_pulses();
    chk("R2 ier", {4'h0, ier_o}, 8'h05);

    // R3/R4/R5/R6 sweep: src bits {modem, thr, data, timeout, line}
    for (int e = 0; e < 16; e++) begin
      for (int s = 0; s < 32; s++) begin
        logic [3:0] id;
        ier_we = 1; ier_wdata = {4'hA, e[3:0]}; thr_empty = 0;
        lsr_rd = 1;
        pe = s[0]; tout = s[1]; dr = s[2]; fifo_en = 0;
        thre_set = s[3]; thr_write = !s[3];
        msd = s[4] ? 4'b0100 : 4'b0000;
        step(); clear_pulses();
        id = exp_id(e[3:0], s[4:0]);
        chk("R3 R4 R5 R6 iir", iir_o, {4'h0, id});
        chk("R4 irq", {7'h0, irq_o}, {7'h0, id != 4'h1});
      end
    end
    pe = 0; tout = 0; dr = 0; msd = 0; thr_write = 1; step(); clear_pulses();

    // R7 + R11 FIFO threshold sweep
    ier_we = 1; ier_wdata = 8'h01; fifo_en = 1; dr = 1; trig = 4; step(); clear_pulses();
    for (int c = 0; c <= 16; c++) begin
      cnt = c[CNT_W-1:0]; step();
      chk("R7 R11 fifo", iir_o, (c >= 4) ? 8'hC4 : 8'hC1);
    end
    dr = 0; cnt = 8; step();
    chk("R7 no dr", iir_o, 8'hC1);
    fifo_en = 0; dr = 1; cnt = 0; step();
    chk("R7 R11 nofifo", iir_o, 8'h04);
    dr = 0; fifo_en = 1;

    // R9 enable write with holding empty
    thr_empty = 1; ier_we = 1; ier_wdata = 8'h02; step(); clear_pulses(); thr_empty = 0;
    chk("R9 set", iir_o, 8'hC2);

    // R8 read clears
    iir_rd = 1; step(); clear_pulses();
    chk("R8 cleared", iir_o, 8'hC1);

    // R12 set / clear, and set beats read-clear
    thre_set = 1; step(); clear_pulses();
    chk("R12 set", iir_o, 8'hC2);
    iir_rd = 1; thre_set = 1; step(); clear_pulses();
    chk("R8 R12 collide", iir_o, 8'hC2);
    thr_write = 1; step(); clear_pulses();
    chk("R12 clear", iir_o, 8'hC1);

    // R8 read of another code keeps pending
    ier_we = 1; ier_wdata = 8'h0A; msd = 4'b0001; step(); clear_pulses();
    chk("R8 modem", iir_o, 8'hC0);
    thre_set = 1; step(); clear_pulses();
    chk("R3 thr over modem", iir_o, 8'hC2);
    ier_we = 1; ier_wdata = 8'h08; step(); clear_pulses();
    iir_rd = 1; step(); clear_pulses();
    ier_we = 1; ier_wdata = 8'h0A; step(); clear_pulses();
    chk("R8 pend kept", iir_o, 8'hC2);
    msd = 0; thr_write = 1; step(); clear_pulses();

    // R10 error flags
    ier_we = 1; ier_wdata = 8'h04; oe_set = 1; bi_set = 1; pe = 1; fe = 1; step(); clear_pulses();
    chk("R10 all", {4'h0, err_o}, 8'h0F);
    chk("R5 line", iir_o, 8'hC6);
    lsr_rd = 1; step(); clear_pulses();
    chk("R10 read", {4'h0, err_o}, 8'h06);
    pe = 0; fe = 0; step();
    chk("R5 idle", iir_o, 8'hC1);
    oe_set = 1; step(); clear_pulses();
    lsr_rd = 1; oe_set = 1; step(); clear_pulses();
    chk("R10 collide", {4'h0, err_o}, 8'h01);
    lsr_rd = 1; step(); clear_pulses();
    chk("R10 clear", {4'h0, err_o}, 8'h00);

    // R13 latency
    ier_we = 1; ier_wdata = 8'h08; step(); clear_pulses();
    @(posedge clk); #1 msd = 4'b1000;
    @(negedge clk);
    chk("R13 before", iir_o, 8'hC1);
    step();
    chk("R13 after", iir_o, 8'hC0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule